// File: doc/BRIEF.md
# Reset-Time Flash-to-RAM Boot Copier

This block runs once after every reset. It keeps the processor held and owns the system Wishbone bus. It reads a program image from a serial flash device over SPI and stores that image into processor RAM as 32-bit Wishbone writes. When the last word has been accepted, it gives the bus back. One cycle later it lets the processor go, and the processor starts fetching at its reset vector. The block then stays quiet until the next reset.

The image layout is fixed at build time through parameters:
- the flash start address;
- the number of 32-bit words in the image;
- the RAM base address;
- the reset vector presented to the processor;
- the SPI clock divider.

Word assembly overlaps with the Wishbone write of the previous word. When RAM answers slowly, the serial clock pauses until the pending write is accepted, so no data is ever lost.

Top module: `bootfill_master`

## Requirements
- R1: In the first cycle after reset, `cpu_hold` and `bus_grant` are 1, `boot_done` is 0, `spi_cs_n` is 0, `spi_sclk` is 0 and `wb_cyc_o` is 0. `cpu_boot_pc` always equals the RESET_VECTOR parameter.
- R2: SPI runs in mode 0. `spi_sclk` idles low and each high phase lasts exactly CLK_DIV clocks. `spi_mosi` changes only while `spi_sclk` is low, `spi_miso` is taken at the rising edge, and bits travel most significant first. `spi_sclk` only toggles while `spi_cs_n` is 0.
- R3: The first four bytes shifted out are the read opcode 0x03 and then bits 23:16, 15:8 and 7:0 of FLASH_ADDR. Every later byte shifted out is 0x00.
- R4: Each run of four received data bytes forms one word, with the earliest byte placed in bits 31:24 and the latest in bits 7:0.
- R5: Each word is written with `wb_cyc_o`, `wb_stb_o` and `wb_we_o` at 1 and `wb_sel_o` at 4'hF. Word n goes to address RAM_BASE + 4*n. Address and data stay unchanged until `wb_ack_i` is seen, and `wb_cyc_o` is only high while `bus_grant` is 1.
- R6: Exactly WORD_COUNT writes are issued, and exactly 4 + 4*WORD_COUNT bytes are clocked on the SPI pins.
- R7: A new word can become ready while the previous write still waits for ack. In that case no further byte is clocked until that write is accepted. The waiting word is then presented in the cycle right after the ack, with `wb_cyc_o` staying high.
- R8: The last ack is taken at one clock edge. From that edge on, `spi_cs_n` is 1, `bus_grant` is 0, `wb_cyc_o` is 0 and `cpu_hold` is still 1. One edge later, `cpu_hold` is 0 and `boot_done` is 1.
- R9: Once `boot_done` is 1, activity on `wb_ack_i` and `spi_miso` has no effect. `wb_cyc_o` stays 0, `spi_cs_n` stays 1, `spi_sclk` stays 0 and `cpu_hold` stays 0.
- R10: A `wb_ack_i` pulse while `wb_cyc_o` is 0 during the copy is ignored. It neither advances the address nor counts as a written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_adr_o | output | ADDR_W | Wishbone byte address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| cpu_hold | output | 1 | Holds the processor frozen while high |
| bus_grant | output | 1 | High while this block owns the bus |
| boot_done | output | 1 | High once the processor has been released |
| cpu_boot_pc | output | ADDR_W | Reset vector for the processor |

## Verification
The delicate coincidence is a word that finishes assembling while the write of the previous word is still waiting. The hand-off of the new word and the ack of the old one then fall in the same clock. The bench provokes this with a RAM model that holds ack back for far longer than one word takes to arrive over SPI. It judges the result three ways: `wb_cyc_o` stays high across each ack, every word lands at the right address with the right value, and the total byte count on the pins matches the image size. A second scenario injects ack pulses outside any cycle to show that they are not counted.

// File: rtl/bootfill_pkg.sv
package bootfill_pkg;

    localparam logic [7:0] READ_OPCODE    = 8'h03;
    localparam int         CMD_BYTES      = 4;
    localparam int         BYTES_PER_WORD = 4;
    localparam int         WORD_W         = 8 * BYTES_PER_WORD;

    typedef enum logic [1:0] {
        PH_CMD     = 2'd0,
        PH_DATA    = 2'd1,
        PH_RELEASE = 2'd2,
        PH_IDLE    = 2'd3
    } phase_e;

    typedef struct packed {
        logic [2:0] cnt;
        logic [WORD_W-1:0] word;
    } pack_state_t;

    function automatic logic [7:0] cmd_byte(input logic [2:0] idx, input logic [23:0] faddr);
        case (idx)
            3'd0:    cmd_byte = READ_OPCODE;
            3'd1:    cmd_byte = faddr[23:16];
            3'd2:    cmd_byte = faddr[15:8];
            default: cmd_byte = faddr[7:0];
        endcase
    endfunction

endpackage

// File: rtl/bootfill_spi.sv
module bootfill_spi #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;
    logic             sclk_q;
    logic             busy_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    tx_q   <= tx_byte;
                    div_q  <= '0;
                    bit_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_byte = rx_q;
    assign sclk    = sclk_q;
    assign mosi    = tx_q[7];

    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> (mosi == $past(mosi)));  // R2
    AST_DONE_ENDS_LOW: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!sclk_q && !busy_q));  // R2

endmodule

// File: rtl/bootfill_pack.sv
module bootfill_pack
    import bootfill_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [7:0]        byte_in,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word
);
    pack_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (take) begin
            st_q.cnt <= '0;
        end else if (push) begin
            st_q.cnt  <= st_q.cnt + 3'd1;
            st_q.word <= {st_q.word[WORD_W-9:0], byte_in};
        end
    end

    assign full = (st_q.cnt == 3'(BYTES_PER_WORD));
    assign word = st_q.word;

    AST_PACK_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);  // R7
    AST_PACK_TAKE_FULL: assert property (@(posedge clk) disable iff (rst)
        take |-> full);  // R4

endmodule

// File: rtl/bootfill_wbw.sv
module bootfill_wbw
    import bootfill_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RAM_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_dat,
    input  logic              ack,
    output logic              free,
    output logic              accepted,
    output logic              cyc,
    output logic              stb,
    output logic              we,
    output logic [3:0]        sel,
    output logic [ADDR_W-1:0] adr,
    output logic [WORD_W-1:0] dat
);
    logic              cyc_q;
    logic [ADDR_W-1:0] adr_q;
    logic [WORD_W-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= 1'b0;
            adr_q <= RAM_BASE;
            dat_q <= '0;
        end else begin
            if (cyc_q && ack) begin
                cyc_q <= 1'b0;
                adr_q <= adr_q + ADDR_W'(BYTES_PER_WORD);
            end
            if (load) begin
                cyc_q <= 1'b1;
                dat_q <= load_dat;
            end
        end
    end

    assign free     = !cyc_q || ack;
    assign accepted = cyc_q && ack;
    assign cyc      = cyc_q;
    assign stb      = cyc_q;
    assign we       = cyc_q;
    assign sel      = cyc_q ? 4'hF : 4'h0;
    assign adr      = adr_q;
    assign dat      = dat_q;

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc_q && !ack) |=> (cyc_q && $stable(adr_q) && $stable(dat_q)));  // R5
    AST_ADR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cyc_q && ack) |=> (adr_q == $past(adr_q) + ADDR_W'(BYTES_PER_WORD)));  // R5
    AST_NO_ACK_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !cyc_q |=> $stable(adr_q));  // R10
    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        load |-> free);  // R7

endmodule

// File: rtl/bootfill_master.sv
module bootfill_master
    import bootfill_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                CLK_DIV      = 4,
    parameter int                WORD_COUNT   = 256,
    parameter logic [ADDR_W-1:0] RAM_BASE     = '0,
    parameter logic [23:0]       FLASH_ADDR   = 24'h000000,
    parameter logic [ADDR_W-1:0] RESET_VECTOR = ADDR_W'(32'h0000_0100)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [3:0]        wb_sel_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [31:0]       wb_dat_o,
    input  logic              wb_ack_i,
    output logic              cpu_hold,
    output logic              bus_grant,
    output logic              boot_done,
    output logic [ADDR_W-1:0] cpu_boot_pc
);
    localparam int TOTAL_BYTES = WORD_COUNT * BYTES_PER_WORD;
    localparam int CNT_W       = $clog2(TOTAL_BYTES + 1);
    localparam int WC_W        = $clog2(WORD_COUNT + 1);

    phase_e           phase_q;
    logic [2:0]       cmd_q;
    logic [CNT_W-1:0] started_q;
    logic [WC_W-1:0]  written_q;

    logic        spi_busy, spi_done, spi_start;
    logic [7:0]  spi_rx, tx_byte;
    logic        pack_full, pack_push, pack_take;
    logic [WORD_W-1:0] pack_word;
    logic        wr_free, wr_accept, ack_eff, last_accept;
    logic        in_cmd, in_data;

    assign in_cmd  = (phase_q == PH_CMD);
    assign in_data = (phase_q == PH_DATA);

    assign spi_start = !spi_busy && !spi_done &&
                       ((in_cmd && (cmd_q < 3'(CMD_BYTES))) ||
                        (in_data && !pack_full && (started_q != CNT_W'(TOTAL_BYTES))));
    assign tx_byte   = in_cmd ? cmd_byte(cmd_q, FLASH_ADDR) : 8'h00;

    assign pack_push   = spi_done && in_data;
    assign pack_take   = pack_full && wr_free && in_data;
    assign ack_eff     = wb_ack_i && in_data;
    assign last_accept = wr_accept && (written_q == WC_W'(WORD_COUNT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_CMD;
            cmd_q     <= '0;
            started_q <= '0;
            written_q <= '0;
        end else begin
            if (spi_start && in_cmd)  cmd_q     <= cmd_q + 3'd1;
            if (spi_start && in_data) started_q <= started_q + 1'b1;
            if (wr_accept)            written_q <= written_q + 1'b1;
            case (phase_q)
                PH_CMD:     if (spi_done && (cmd_q == 3'(CMD_BYTES))) phase_q <= PH_DATA;
                PH_DATA:    if (last_accept) phase_q <= PH_RELEASE;
                PH_RELEASE: phase_q <= PH_IDLE;
                default:    phase_q <= PH_IDLE;
            endcase
        end
    end

    bootfill_spi #(.CLK_DIV(CLK_DIV)) u_spi (
        .clk     (clk),
        .rst     (rst),
        .start   (spi_start),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .busy    (spi_busy),
        .done    (spi_done),
        .rx_byte (spi_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    bootfill_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .push    (pack_push),
        .byte_in (spi_rx),
        .take    (pack_take),
        .full    (pack_full),
        .word    (pack_word)
    );

    bootfill_wbw #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)) u_wbw (
        .clk      (clk),
        .rst      (rst),
        .load     (pack_take),
        .load_dat (pack_word),
        .ack      (ack_eff),
        .free     (wr_free),
        .accepted (wr_accept),
        .cyc      (wb_cyc_o),
        .stb      (wb_stb_o),
        .we       (wb_we_o),
        .sel      (wb_sel_o),
        .adr      (wb_adr_o),
        .dat      (wb_dat_o)
    );

    assign spi_cs_n    = !(in_cmd || in_data);
    assign bus_grant   = in_cmd || in_data;
    assign cpu_hold    = (phase_q != PH_IDLE);
    assign boot_done   = (phase_q == PH_IDLE);
    assign cpu_boot_pc = RESET_VECTOR;

    AST_CYC_OWNED: assert property (@(posedge clk) disable iff (rst)
        wb_cyc_o |-> bus_grant);  // R5
    AST_SCLK_SELECTED: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n);  // R2
    AST_HANDBACK: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_grant) |-> (cpu_hold && spi_cs_n && !wb_cyc_o));  // R8
    AST_HOLD_LAGS: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_grant) |=> (!cpu_hold && boot_done));  // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> (!wb_cyc_o && spi_cs_n && !spi_sclk && !cpu_hold));  // R9
    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done);  // R9

endmodule

// File: tb/bootfill_master_tb.sv
module bootfill_master_tb;
    localparam int          DIV   = 2;
    localparam int          WC    = 3;
    localparam logic [31:0] BASE  = 32'h0000_2000;
    localparam logic [31:0] VEC   = 32'h0000_2040;
    localparam logic [23:0] FADDR = 24'h01A2B3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;
    logic wb_cyc_o, wb_stb_o, wb_we_o;
    logic [3:0]  wb_sel_o;
    logic [31:0] wb_adr_o, wb_dat_o;
    logic wb_ack_i = 1'b0;
    logic cpu_hold, bus_grant, boot_done;
    logic [31:0] cpu_boot_pc;

    always #5 clk = ~clk;

    bootfill_master #(
        .ADDR_W(32), .CLK_DIV(DIV), .WORD_COUNT(WC),
        .RAM_BASE(BASE), .FLASH_ADDR(FADDR), .RESET_VECTOR(VEC)
    ) u_dut (
        .clk(clk), .rst(rst),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_ack_i(wb_ack_i),
        .cpu_hold(cpu_hold), .bus_grant(bus_grant), .boot_done(boot_done),
        .cpu_boot_pc(cpu_boot_pc)
    );

    int n_checks = 0;
    int n_fail   = 0;

    function automatic logic [7:0] fbyte(input int k);
        return 8'(k * 29 + 90);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // flash model
    int g_bits = 0, nbytes = 0, hi_len = 0, hi_err = 0, mosi_err = 0;
    logic [7:0] shreg = 8'h00;
    logic [7:0] cap [0:31];
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    bit flash_en = 1'b1;

    always @(negedge clk) begin
        if (!spi_cs_n) begin
            if (spi_sclk && !prev_sclk) begin
                shreg = {shreg[6:0], spi_mosi};
                g_bits++;
                hi_len = 1;
                if (g_bits % 8 == 0) begin
                    if (nbytes < 32) cap[nbytes] = shreg;
                    nbytes++;
                end
            end else if (spi_sclk && prev_sclk) begin
                hi_len++;
                if (spi_mosi !== prev_mosi) mosi_err++;
            end else if (!spi_sclk && prev_sclk) begin
                if (hi_len != DIV) hi_err++;
            end
        end
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
        if (flash_en) begin
            if (g_bits / 8 < 4) spi_miso = 1'b0;
            else begin
                logic [7:0] b;
                b = fbyte(g_bits / 8 - 4);
                spi_miso = b[7 - (g_bits % 8)];
            end
        end
    end

    // RAM model
    logic [31:0] w_adr [0:15];
    logic [31:0] w_dat [0:15];
    logic [3:0]  w_sel [0:15];
    logic        w_we  [0:15];
    int  nw = 0, stab_err = 0, b2b = 0, wcnt = 0, scnt = 0, ack_delay = 0;
    bit  real_ack = 1'b0, last_ack = 1'b0, stray_en = 1'b0, slave_en = 1'b0;
    logic [31:0] first_adr, first_dat;

    always @(negedge clk) begin
        if (slave_en) begin
            if (wb_ack_i) begin
                wb_ack_i = 1'b0;
                wcnt = 0;
                if (real_ack && wb_cyc_o) b2b++;
                real_ack = 1'b0;
            end else if (wb_cyc_o && wb_stb_o) begin
                if (wcnt == 0) begin
                    first_adr = wb_adr_o;
                    first_dat = wb_dat_o;
                end else if (wb_adr_o !== first_adr || wb_dat_o !== first_dat) begin
                    stab_err++;
                end
                if (wcnt >= ack_delay) begin
                    if (nw < 16) begin
                        w_adr[nw] = wb_adr_o; w_dat[nw] = wb_dat_o;
                        w_sel[nw] = wb_sel_o; w_we[nw]  = wb_we_o;
                    end
                    nw++;
                    wb_ack_i = 1'b1;
                    real_ack = 1'b1;
                    if (nw == WC) last_ack = 1'b1;
                end else begin
                    wcnt++;
                end
            end else if (stray_en && !boot_done) begin
                scnt++;
                if (scnt % 5 == 0) wb_ack_i = 1'b1;
            end
        end
    end

    task automatic do_reset();
        slave_en = 1'b0;
        flash_en = 1'b1;
        stray_en = 1'b0;
        wb_ack_i = 1'b0;
        rst = 1'b1;
        g_bits = 0; nbytes = 0; hi_len = 0; hi_err = 0; mosi_err = 0;
        nw = 0; stab_err = 0; b2b = 0; wcnt = 0; scnt = 0;
        real_ack = 1'b0; last_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        slave_en = 1'b1;
    endtask

    task automatic run_boot(input string tag);
        while (!last_ack) begin
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
        check(spi_cs_n === 1'b1,  "R8", {tag, " cs_n after last ack"}, 32'(spi_cs_n), 1);
        check(bus_grant === 1'b0, "R8", {tag, " grant after last ack"}, 32'(bus_grant), 0);
        check(cpu_hold === 1'b1 && wb_cyc_o === 1'b0, "R8", {tag, " hold kept, cyc low"},
              {30'b0, cpu_hold, wb_cyc_o}, 32'h2);
        @(negedge clk); #1;
        check(cpu_hold === 1'b0 && boot_done === 1'b1, "R8", {tag, " cpu released"},
              {30'b0, cpu_hold, boot_done}, 32'h1);
    endtask

    task automatic check_image(input string tag);
        check(nw == WC, "R6", {tag, " write count"}, nw, WC);
        check(nbytes == 4 + 4 * WC, "R6", {tag, " SPI byte count"}, nbytes, 4 + 4 * WC);
        check(cap[0] == 8'h03, "R3", {tag, " opcode"}, cap[0], 8'h03);
        check({cap[1], cap[2], cap[3]} == FADDR, "R3", {tag, " flash address"},
              {8'h0, cap[1], cap[2], cap[3]}, {8'h0, FADDR});
        for (int i = 4; i < 4 + 4 * WC; i++)
            check(cap[i] == 8'h00, "R3", {tag, " filler byte"}, cap[i], 0);
        check(mosi_err == 0, "R2", {tag, " mosi steady while sclk high"}, mosi_err, 0);
        check(hi_err == 0, "R2", {tag, " sclk high length"}, hi_err, 0);
        check(stab_err == 0, "R5", {tag, " request stable until ack"}, stab_err, 0);
        for (int i = 0; i < WC; i++) begin
            check(w_adr[i] == BASE + 32'(4 * i), "R5", {tag, " address"}, w_adr[i], BASE + 32'(4 * i));
            check(w_sel[i] == 4'hF && w_we[i] == 1'b1, "R5", {tag, " sel/we"},
                  {27'b0, w_we[i], w_sel[i]}, 32'h1F);
            check(w_dat[i] == {fbyte(4*i), fbyte(4*i+1), fbyte(4*i+2), fbyte(4*i+3)}, "R4",
                  {tag, " word data"}, w_dat[i],
                  {fbyte(4*i), fbyte(4*i+1), fbyte(4*i+2), fbyte(4*i+3)});
        end
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check(cpu_hold === 1'b1 && bus_grant === 1'b1 && boot_done === 1'b0, "R1",
              "hold/grant/done after reset", {29'b0, cpu_hold, bus_grant, boot_done}, 32'h6);
        check(spi_cs_n === 1'b0 && spi_sclk === 1'b0 && wb_cyc_o === 1'b0, "R1",
              "cs_n/sclk/cyc after reset", {29'b0, spi_cs_n, spi_sclk, wb_cyc_o}, 0);
        check(cpu_boot_pc === VEC, "R1", "reset vector", cpu_boot_pc, VEC);
    endtask

    task automatic t_fast();
        ack_delay = 0;
        run_boot("fast");
        check_image("fast");
    endtask

    task automatic t_slow();
        do_reset();
        ack_delay = 200;
        run_boot("slow");
        check_image("slow");
        check(b2b == WC - 1, "R7", "back-to-back writes across ack", b2b, WC - 1);
    endtask

    task automatic t_stray();
        do_reset();
        ack_delay = 3;
        stray_en = 1'b1;
        run_boot("stray");
        check_image("stray R10");
    endtask

    task automatic t_idle();
        int bad = 0;
        int nw0 = nw;
        slave_en = 1'b0;
        flash_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wb_cyc_o !== 1'b0 || spi_cs_n !== 1'b1 || spi_sclk !== 1'b0 ||
                cpu_hold !== 1'b0 || boot_done !== 1'b1) bad++;
            wb_ack_i = (i % 2 == 0);
            spi_miso = (i % 3 == 0);
        end
        @(negedge clk);
        wb_ack_i = 1'b0;
        check(bad == 0, "R9", "quiet after done", bad, 0);
        check(nw == nw0, "R9", "no write after done", nw, nw0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fast();
        t_idle();
        t_slow();
        t_stray();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule